// File: doc/BRIEF.md
# Two-Port General-Purpose I/O Controller with Relocatable Access Window

This block drives and samples two eight-pin groups of general-purpose I/O. Each group keeps three bytes of state: a direction mask, a data byte and an inversion mask. A direction bit of 1 makes the pin an input. The inversion mask flips the value on the way out to the pin and on the way back from the pin. The setup interface is an index/data register port. It holds the three-bit activation byte, a two-byte base address and all six per-group registers.

Software running at run time reaches the direction and data bytes of both groups through a second interface, a four-byte I/O window. The window starts at the programmed base, and its two low address bits are forced to zero. The window decodes only when the base lies in a legal range and the addressed group is active. Both interfaces write the same storage, so a change made through one is visible through the other. Input pins pass through a synchronizer before they reach any read path. The per-pin output values and output enables come from registers.

Top module: `gpio_dual_ctrl`

## Requirements
- R1: After a synchronous reset, both direction bytes read FFh. Data, inversion, activation and both base bytes read 00h, and every pin_oe and pin_out bit is 0.
- R2: The activation byte keeps only bits 2:0. Bits 7:3 always read 0.
- R3: Group 0 is active when activation bit 0 or bit 1 is 1. Group 1 is active when activation bit 0 or bit 2 is 1.
- R4: While a group is inactive, its pin_oe bits are 0. Window reads of its two bytes return 00h and window writes to them are dropped. Its setup registers can still be written and read.
- R5: pin_oe bit n of an active group is the inverse of its direction bit n. It appears one cycle after the direction register changes.
- R6: pin_out bit n is the stored data bit XOR the inversion bit. It appears one cycle after either register changes.
- R7: A data read returns, for each input bit (direction 1), the synchronized pin level XOR the inversion bit. For each output bit (direction 0), it returns the stored data bit. Pins are sampled through two flops.
- R8: The window base is {index 60h, index 61h} with bits 1:0 taken as 0. It decodes only when it lies from 0100h to 0FF8h inclusive. Otherwise every window read returns 00h.
- R9: In the window, offset 0 selects group 0 direction, offset 1 group 0 data, offset 2 group 1 direction and offset 3 group 1 data.
- R10: Window and setup accesses share storage. When both write the same register in one cycle, the setup write wins.
- R11: Writes to undefined indices are dropped, and reads of them return 00h. Read data is registered one cycle after the strobe and is 00h in cycles without a read strobe.
- R12: The setup index map is as follows. 30h is activation, 60h the base high byte and 61h the base low byte. F0h, F1h and F2h are group 0 direction, data and inversion. F3h, F4h and F5h are the same for group 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx | input | 8 | Setup register index |
| cfg_wdata | input | 8 | Setup write data |
| cfg_wr | input | 1 | Setup write strobe |
| cfg_rd | input | 1 | Setup read strobe |
| cfg_rdata | output | 8 | Setup read data, registered |
| io_addr | input | 16 | Window access address |
| io_wdata | input | 8 | Window write data |
| io_wr | input | 1 | Window write strobe |
| io_rd | input | 1 | Window read strobe |
| io_rdata | output | 8 | Window read data, registered |
| pin_in | input | 16 | Pin levels, group 0 in bits 7:0 |
| pin_out | output | 16 | Driven pin values, group 0 in bits 7:0 |
| pin_oe | output | 16 | Per-pin output enables, group 0 in bits 7:0 |

## Verification
The bench reads a data byte that mixes input and output bits, with and without inversion. A design that inverted the stored output bits on read-back, or that failed to invert the pin levels, would return a wrong byte.

The window base is placed just inside and just outside both ends of its legal range, and with its low bits set. An off-by-one range test, or a base whose low bits were not masked, would decode where it must not, or miss where it must.

Each group is made active first by its own bit alone and then by the global bit. Stray window writes are aimed at an inactive group. The enable logic is therefore caught if it uses AND instead of OR, or if it lets writes through to a disabled group.

Finally, one cycle carries a setup write and a window write to the same register. The bench checks that the setup value is the one kept.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
  localparam int NUM_PORTS     = 2;
  localparam int IDX_ACT       = 'h30;
  localparam int IDX_BASE_HI   = 'h60;
  localparam int IDX_BASE_LO   = 'h61;
  localparam int IDX_PORT_BASE = 'hF0;
  localparam int IDX_PORT_STEP = 3;
  localparam int ACT_BITS      = 3;
  localparam int ACT_GLOBAL    = 0;
endpackage

// File: rtl/gpio_cfg_core.sv
module gpio_cfg_core
  import gpio_dual_pkg::*;
#(
  parameter int GP_W  = 8,
  parameter int IDX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic [GP_W-1:0]       cfg_wdata,
  input  logic                  cfg_wr,
  output logic [ACT_BITS-1:0]   act_q,
  output logic [2*GP_W-1:0]     base_raw,
  output logic [NUM_PORTS-1:0]  port_act
);
  logic [GP_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (cfg_wr) begin
      if (cfg_idx == IDX_W'(IDX_ACT))     act_q <= cfg_wdata[ACT_BITS-1:0];
      if (cfg_idx == IDX_W'(IDX_BASE_HI)) hi_q  <= cfg_wdata;
      if (cfg_idx == IDX_W'(IDX_BASE_LO)) lo_q  <= cfg_wdata;
    end
  end

  assign base_raw = {hi_q, lo_q};

  // a group is live through the global bit or through its own bit
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_act
    assign port_act[p] = act_q[ACT_GLOBAL] | act_q[p+1];
  end
endmodule

// File: rtl/gpio_win_decode.sv
module gpio_win_decode #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE_MIN = 16'h0100,
  parameter logic [15:0] BASE_MAX = 16'h0FF8
) (
  input  logic [ADDR_W-1:0] base_raw,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              hit,
  output logic              port_sel,
  output logic              reg_sel
);
  logic [ADDR_W-1:0] base_al;
  logic              legal;

  assign base_al  = {base_raw[ADDR_W-1:2], 2'b00};
  assign legal    = (base_al >= ADDR_W'(BASE_MIN)) && (base_al <= ADDR_W'(BASE_MAX));
  assign hit      = legal && (io_addr[ADDR_W-1:2] == base_al[ADDR_W-1:2]);
  assign port_sel = io_addr[1];
  assign reg_sel  = io_addr[0];
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int GP_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            wr_dir,
  input  logic [GP_W-1:0] wd_dir,
  input  logic            wr_dat,
  input  logic [GP_W-1:0] wd_dat,
  input  logic            wr_inv,
  input  logic [GP_W-1:0] wd_inv,
  input  logic [GP_W-1:0] pin_in,
  output logic [GP_W-1:0] dir_q,
  output logic [GP_W-1:0] inv_q,
  output logic [GP_W-1:0] rd_view,
  output logic [GP_W-1:0] pin_out,
  output logic [GP_W-1:0] pin_oe
);
  logic [GP_W-1:0] dat_q;
  logic [GP_W-1:0] sync_q [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      dat_q <= '0;
      inv_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wd_dir;
      if (wr_dat) dat_q <= wd_dat;
      if (wr_inv) inv_q <= wd_inv;
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst)         sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= pin_in;
      else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  // input bits show the (possibly inverted) pin, output bits the stored byte
  assign rd_view = (dir_q & (sync_q[SYNC_STAGES-1] ^ inv_q)) | (~dir_q & dat_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= dat_q ^ inv_q;
      pin_oe  <= active ? ~dir_q : '0;
    end
  end
endmodule

// File: rtl/gpio_dual_ctrl.sv
module gpio_dual_ctrl
  import gpio_dual_pkg::*;
#(
  parameter int          GP_W        = 8,
  parameter int          IDX_W       = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] BASE_MIN    = 16'h0100,
  parameter logic [15:0] BASE_MAX    = 16'h0FF8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [IDX_W-1:0]          cfg_idx,
  input  logic [GP_W-1:0]           cfg_wdata,
  input  logic                      cfg_wr,
  input  logic                      cfg_rd,
  output logic [GP_W-1:0]           cfg_rdata,
  input  logic [2*GP_W-1:0]         io_addr,
  input  logic [GP_W-1:0]           io_wdata,
  input  logic                      io_wr,
  input  logic                      io_rd,
  output logic [GP_W-1:0]           io_rdata,
  input  logic [NUM_PORTS*GP_W-1:0] pin_in,
  output logic [NUM_PORTS*GP_W-1:0] pin_out,
  output logic [NUM_PORTS*GP_W-1:0] pin_oe
);
  localparam int ADDR_W = 2 * GP_W;

  logic [ACT_BITS-1:0]  act_q;
  logic [ADDR_W-1:0]    base_raw;
  logic [NUM_PORTS-1:0] port_act;
  logic                 dec_hit, dec_port, dec_reg;
  logic [GP_W-1:0]      port_dir  [NUM_PORTS];
  logic [GP_W-1:0]      port_inv  [NUM_PORTS];
  logic [GP_W-1:0]      port_view [NUM_PORTS];
  logic [GP_W-1:0]      cfg_rd_val, io_rd_val;

  gpio_cfg_core #(.GP_W(GP_W), .IDX_W(IDX_W)) cfg_i (
    .clk(clk), .rst(rst), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_wr(cfg_wr), .act_q(act_q), .base_raw(base_raw), .port_act(port_act)
  );

  gpio_win_decode #(.ADDR_W(ADDR_W), .BASE_MIN(BASE_MIN), .BASE_MAX(BASE_MAX)) dec_i (
    .base_raw(base_raw), .io_addr(io_addr), .hit(dec_hit),
    .port_sel(dec_port), .reg_sel(dec_reg)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [IDX_W-1:0] I_DIR = IDX_W'(IDX_PORT_BASE + IDX_PORT_STEP*p);
    localparam logic [IDX_W-1:0] I_DAT = IDX_W'(IDX_PORT_BASE + IDX_PORT_STEP*p + 1);
    localparam logic [IDX_W-1:0] I_INV = IDX_W'(IDX_PORT_BASE + IDX_PORT_STEP*p + 2);

    logic c_dir, c_dat, c_inv, w_hit, w_dir, w_dat;

    assign c_dir = cfg_wr && (cfg_idx == I_DIR);
    assign c_dat = cfg_wr && (cfg_idx == I_DAT);
    assign c_inv = cfg_wr && (cfg_idx == I_INV);
    assign w_hit = io_wr && dec_hit && (dec_port == 1'(p)) && port_act[p];
    assign w_dir = w_hit && !dec_reg;
    assign w_dat = w_hit &&  dec_reg;

    gpio_port_bank #(.GP_W(GP_W), .SYNC_STAGES(SYNC_STAGES)) bank_i (
      .clk(clk), .rst(rst), .active(port_act[p]),
      .wr_dir(c_dir | w_dir), .wd_dir(c_dir ? cfg_wdata : io_wdata),
      .wr_dat(c_dat | w_dat), .wd_dat(c_dat ? cfg_wdata : io_wdata),
      .wr_inv(c_inv),         .wd_inv(cfg_wdata),
      .pin_in(pin_in[p*GP_W +: GP_W]),
      .dir_q(port_dir[p]), .inv_q(port_inv[p]), .rd_view(port_view[p]),
      .pin_out(pin_out[p*GP_W +: GP_W]), .pin_oe(pin_oe[p*GP_W +: GP_W])
    );
  end

  always_comb begin
    cfg_rd_val = '0;
    if (cfg_idx == IDX_W'(IDX_ACT))     cfg_rd_val = GP_W'(act_q);
    if (cfg_idx == IDX_W'(IDX_BASE_HI)) cfg_rd_val = base_raw[ADDR_W-1:GP_W];
    if (cfg_idx == IDX_W'(IDX_BASE_LO)) cfg_rd_val = base_raw[GP_W-1:0];
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (cfg_idx == IDX_W'(IDX_PORT_BASE + IDX_PORT_STEP*p))     cfg_rd_val = port_dir[p];
      if (cfg_idx == IDX_W'(IDX_PORT_BASE + IDX_PORT_STEP*p + 1)) cfg_rd_val = port_view[p];
      if (cfg_idx == IDX_W'(IDX_PORT_BASE + IDX_PORT_STEP*p + 2)) cfg_rd_val = port_inv[p];
    end
  end

  always_comb begin
    io_rd_val = '0;
    if (dec_hit && port_act[dec_port])
      io_rd_val = dec_reg ? port_view[dec_port] : port_dir[dec_port];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
      io_rdata  <= '0;
    end else begin
      cfg_rdata <= cfg_rd ? cfg_rd_val : '0;
      io_rdata  <= io_rd  ? io_rd_val  : '0;
    end
  end
endmodule

// File: rtl/gpio_dual_ctrl_chk.sv
module gpio_dual_ctrl_chk #(
  parameter int GP_W  = 8,
  parameter int IDX_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [IDX_W-1:0]    cfg_idx,
  input logic                cfg_wr,
  input logic                cfg_rd,
  input logic [GP_W-1:0]     cfg_rdata,
  input logic [2*GP_W-1:0]   io_addr,
  input logic                io_wr,
  input logic                io_rd,
  input logic [GP_W-1:0]     io_rdata,
  input logic [2*GP_W-1:0]   pin_out,
  input logic [2*GP_W-1:0]   pin_oe,
  input logic [1:0]          port_act
);
  logic idx_known;
  assign idx_known = (cfg_idx == IDX_W'('h30)) || (cfg_idx == IDX_W'('h60)) ||
                     (cfg_idx == IDX_W'('h61)) ||
                     (cfg_idx >= IDX_W'('hF0) && cfg_idx <= IDX_W'('hF5));

  p_rst_oe_r1: assert property (@(posedge clk) rst |=> pin_oe == '0);

  p_act_rsvd_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_idx == IDX_W'('h30)) |=> cfg_rdata[GP_W-1:3] == '0);

  for (genvar p = 0; p < 2; p++) begin : g_oe
    p_idle_oe_r4: assert property (@(posedge clk) disable iff (rst)
      !port_act[p] |=> pin_oe[p*GP_W +: GP_W] == '0);
  end

  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_wr && !io_wr && !$past(cfg_wr) && !$past(io_wr)) |=> $stable(pin_out));

  p_far_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr[2*GP_W-1:12] != '0) |=> io_rdata == '0);

  p_undef_idx_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && !idx_known) |=> cfg_rdata == '0);
endmodule

bind gpio_dual_ctrl gpio_dual_ctrl_chk #(.GP_W(GP_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_idx(cfg_idx), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_rdata(cfg_rdata), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_rdata(io_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .port_act(port_act)
);

// File: tb/gpio_dual_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_dual_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_idx = '0, cfg_wdata = '0, cfg_rdata;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] pin_in = '0, pin_out, pin_oe;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  gpio_dual_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {req[3:0], kind[1:0], addr[15:0], data[7:0], expect[7:0]}
  // kind: 0 setup write, 1 setup read, 2 window write, 3 window read
  localparam int NV = 19;
  localparam logic [37:0] VEC [NV] = '{
    {4'd12, 2'd0, 16'h0060, 8'h03, 8'h00},  // R12 base high
    {4'd12, 2'd0, 16'h0061, 8'h02, 8'h00},  // R12 base low, bit1 ignored in decode
    {4'd8,  2'd1, 16'h0061, 8'h00, 8'h02},  // R8 raw low byte reads back
    {4'd3,  2'd0, 16'h0030, 8'hFF, 8'h00},  // R3 all activation bits
    {4'd2,  2'd1, 16'h0030, 8'h00, 8'h07},  // R2 reserved bits zero
    {4'd9,  2'd2, 16'h0300, 8'h0F, 8'h00},  // R9 group0 direction
    {4'd10, 2'd1, 16'h00F0, 8'h00, 8'h0F},  // R10 visible in setup space
    {4'd9,  2'd2, 16'h0301, 8'hA0, 8'h00},  // R9 group0 data
    {4'd7,  2'd3, 16'h0301, 8'h00, 8'hAC},  // R7 mixed read
    {4'd6,  2'd0, 16'h00F2, 8'h03, 8'h00},  // R6 group0 inversion
    {4'd7,  2'd3, 16'h0301, 8'h00, 8'hAF},  // R7 inverted inputs only
    {4'd9,  2'd3, 16'h0302, 8'h00, 8'hFF},  // R9 group1 direction
    {4'd9,  2'd3, 16'h0303, 8'h00, 8'hA5},  // R9 group1 pins
    {4'd12, 2'd0, 16'h00F5, 8'hFF, 8'h00},  // R12 group1 inversion
    {4'd7,  2'd3, 16'h0303, 8'h00, 8'h5A},  // R7 inverted pins
    {4'd9,  2'd3, 16'h0304, 8'h00, 8'h00},  // R9 beyond window
    {4'd11, 2'd0, 16'h0077, 8'h55, 8'h00},  // R11 undefined write
    {4'd11, 2'd1, 16'h0077, 8'h00, 8'h00},  // R11 undefined read
    {4'd12, 2'd1, 16'h00F5, 8'h00, 8'hFF}   // R12 group1 inversion read
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk); cfg_idx = idx; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] idx, output logic [7:0] d);
    @(negedge clk); cfg_idx = idx; cfg_rd = 1'b1;
    @(negedge clk); d = cfg_rdata; cfg_rd = 1'b0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); d = io_rdata; io_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", pin_oe, 16'h0000);
    chk("R1 out", pin_out, 16'h0000);
    cfg_read(8'h30, r); chk("R1 act", {8'h0, r}, 16'h0000);
    cfg_read(8'h60, r); chk("R1 hi", {8'h0, r}, 16'h0000);
    cfg_read(8'hF0, r); chk("R1 dir0", {8'h0, r}, 16'h00FF);
    cfg_read(8'hF3, r); chk("R1 dir1", {8'h0, r}, 16'h00FF);
    cfg_read(8'hF2, r); chk("R1 inv0", {8'h0, r}, 16'h0000);
    cfg_read(8'hF4, r); chk("R1 dat1", {8'h0, r}, 16'h0000);

    pin_in = 16'hA53C;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      case (v[33:32])
        2'd0: cfg_write(v[23:16], v[15:8]);
        2'd2: io_write(v[31:16], v[15:8]);
        2'd1: begin
          cfg_read(v[23:16], r);
          chk($sformatf("R%0d vec%0d", v[37:34], i), {8'h0, r}, {8'h0, v[7:0]});
        end
        default: begin
          io_read(v[31:16], r);
          chk($sformatf("R%0d vec%0d", v[37:34], i), {8'h0, r}, {8'h0, v[7:0]});
        end
      endcase
    end

    // R5 R6 pin drive after table
    @(negedge clk);
    chk("R6 pins", pin_out, 16'hFFA3);
    chk("R5 oe", pin_oe, 16'h00F0);
    chk("R11 idle rdata", {cfg_rdata, io_rdata}, 16'h0000);

    // R4 group0 inactive, group1 by own bit (R3)
    cfg_write(8'h30, 8'h04);
    @(negedge clk);
    chk("R4 oe off", pin_oe, 16'h0000);
    io_read(16'h0301, r); chk("R4 read", {8'h0, r}, 16'h0000);
    io_write(16'h0300, 8'h00);
    cfg_read(8'hF0, r); chk("R4 write dropped", {8'h0, r}, 16'h000F);
    cfg_write(8'hF2, 8'h00);
    cfg_read(8'hF2, r); chk("R4 setup live", {8'h0, r}, 16'h0000);
    cfg_write(8'hF2, 8'h03);
    io_read(16'h0302, r); chk("R3 own bit g1", {8'h0, r}, 16'h00FF);

    // R3 group0 by own bit, group1 inactive
    cfg_write(8'h30, 8'h02);
    @(negedge clk);
    chk("R3 oe g0", pin_oe, 16'h00F0);
    io_read(16'h0303, r); chk("R3 g1 off", {8'h0, r}, 16'h0000);
    io_read(16'h0300, r); chk("R3 own bit g0", {8'h0, r}, 16'h000F);
    cfg_write(8'h30, 8'h01);

    // R8 base range edges
    cfg_write(8'h60, 8'h0F); cfg_write(8'h61, 8'hFC);
    io_read(16'h0FFC, r); chk("R8 above max", {8'h0, r}, 16'h0000);
    cfg_write(8'h61, 8'hF8);
    io_read(16'h0FF8, r); chk("R8 at max", {8'h0, r}, 16'h000F);
    cfg_write(8'h60, 8'h00); cfg_write(8'h61, 8'hFC);
    io_read(16'h00FC, r); chk("R8 below min", {8'h0, r}, 16'h0000);
    cfg_write(8'h60, 8'h01); cfg_write(8'h61, 8'h03);
    io_read(16'h0100, r); chk("R8 low bits masked", {8'h0, r}, 16'h000F);
    io_read(16'h0103, r); chk("R9 g1 data", {8'h0, r}, 16'h005A);

    // R10 simultaneous writes: setup wins
    @(negedge clk);
    cfg_idx = 8'hF0; cfg_wdata = 8'h33; cfg_wr = 1'b1;
    io_addr = 16'h0100; io_wdata = 8'hCC; io_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0; io_wr = 1'b0;
    cfg_read(8'hF0, r); chk("R10 setup wins", {8'h0, r}, 16'h0033);
    io_write(16'h0101, 8'h5F);
    cfg_read(8'hF1, r); chk("R7 R10 alias mix", {8'h0, r}, 16'h007F);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule